// File: doc/BRIEF.md
# Pair-and-Spare Reconfiguration Controller

This block supervises a pool of identical computing modules. Two of them form the active pair and run in lockstep. Every cycle the block takes in each module's result word and its error-report flag. It compares the two active results bit by bit. While the two results agree, it forwards the result of slot A as the system output, and the spare modules stay out of use.

When the active pair disagrees, the error flags decide which member is faulty. That member is retired and replaced by the healthy spare with the highest priority. If neither active module has reported an error, both are treated as suspect. Both are swapped out when at least two healthy spares exist; otherwise the block raises a mismatch-unresolved flag.

Any module that raises its error flag, even for one cycle, is marked faulty for good. A reconfiguration takes one cycle, during which the output is invalid. Once fewer than two unmarked modules remain, the block declares the pool exhausted and keeps the output invalid until reset.

Top module: `pas_reconfig_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears every fault mark, selects module 0 as slot A and module 1 as slot B, and leaves `busy`, `exhausted` and `unresolved` low.
- R2: Module i's result occupies `mod_result[i*DATA_W +: DATA_W]`. While the two active results are equal and the block is neither busy nor exhausted, `sys_valid` is high, `sys_out` equals the slot A result, and the selection does not change at the next edge, whatever the spares present.
- R3: On a mismatch where exactly one active module is faulty (error flag high now, or marked earlier), only that slot is refilled at the next edge. The other slot keeps its module.
- R4: Spares are picked by fixed priority: the lowest-numbered module that is neither active, marked, nor flagging this cycle comes first. When two are needed, the first goes to slot A and the second to slot B.
- R5: A module whose error flag has been high in any cycle is never selected afterwards, including in the same cycle in which a replacement is picked.
- R6: After a reconfiguring edge, `busy` is high for exactly one cycle with `sys_valid` low. Comparison resumes on the new pair in the following cycle.
- R7: On a mismatch with no active module faulty and at least two eligible spares, both active modules are marked faulty and both slots are refilled.
- R8: On a mismatch with no active module faulty and fewer than two eligible spares, `unresolved` is high in that same cycle, `sys_valid` is low, and the selection is unchanged.
- R9: When fewer than two unmarked modules remain, `exhausted` rises at the next edge and stays high with `sys_valid` low until reset.
- R10: On a mismatch where both active modules are faulty and two spares exist, both slots are refilled in priority order.
- R11: `act_a` and `act_b` always show the two distinct module indices in slots A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_result | input | NUM_MOD*DATA_W | Result words of all modules, module i at slice i |
| mod_err | input | NUM_MOD | Error-report flag per module |
| sys_out | output | DATA_W | Forwarded result of slot A |
| sys_valid | output | 1 | Output is trustworthy this cycle |
| busy | output | 1 | Reconfiguration cycle in progress |
| exhausted | output | 1 | Fewer than two healthy modules remain (sticky) |
| unresolved | output | 1 | Mismatch with no faulty member and too few spares |
| act_a | output | $clog2(NUM_MOD) | Module index in slot A |
| act_b | output | $clog2(NUM_MOD) | Module index in slot B |

## Verification
Fault marking and spare selection can happen in the same cycle. A spare may raise its error flag in the very cycle in which a mismatch sends the block looking for a replacement. The bench provokes this by flagging an active module together with the lowest-numbered spare during a mismatch. It then judges the outcome by the slot indices in the busy cycle: the flagged spare must be skipped in favour of the next one, and it must never reappear later.

// File: rtl/pas_pkg.sv
package pas_pkg;

   // Decision taken by the swap planner on a given cycle
   typedef enum logic [1:0] {
      PLAN_HOLD      = 2'd0,
      PLAN_REFILL_A  = 2'd1,
      PLAN_REFILL_B  = 2'd2,
      PLAN_REFILL_AB = 2'd3
   } plan_e;

endpackage

// File: rtl/pas_word_sel.sv
module pas_word_sel #(
   parameter int NUM_MOD = 4,
   parameter int DATA_W  = 16,
   parameter int IDX_W   = $clog2(NUM_MOD)
) (
   input  logic [IDX_W-1:0]          sel,
   input  logic [NUM_MOD*DATA_W-1:0] bus,
   output logic [DATA_W-1:0]         word
);

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_MOD; i++) begin
         if (sel == IDX_W'(i)) word = bus[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/pas_spare_pick.sv
module pas_spare_pick #(
   parameter int NUM_MOD   = 4,
   parameter int LOW_FIRST = 1,
   parameter int IDX_W     = $clog2(NUM_MOD),
   parameter int CNT_W     = $clog2(NUM_MOD + 1)
) (
   input  logic [NUM_MOD-1:0] avail,
   output logic [IDX_W-1:0]   first_idx,
   output logic [IDX_W-1:0]   second_idx,
   output logic [CNT_W-1:0]   avail_cnt
);

   initial begin
      if (LOW_FIRST != 0 && LOW_FIRST != 1)
         $error("pas_spare_pick: LOW_FIRST must be 0 or 1");
   end

   // Walk from the lowest priority to the highest so that the last
   // hit lands in first_idx and the one before it in second_idx.
   generate
      if (LOW_FIRST == 1) begin : g_low_first
         always_comb begin
            first_idx  = '0;
            second_idx = '0;
            for (int i = NUM_MOD - 1; i >= 0; i--) begin
               if (avail[i]) begin
                  second_idx = first_idx;
                  first_idx  = IDX_W'(i);
               end
            end
         end
      end else begin : g_high_first
         always_comb begin
            first_idx  = '0;
            second_idx = '0;
            for (int i = 0; i < NUM_MOD; i++) begin
               if (avail[i]) begin
                  second_idx = first_idx;
                  first_idx  = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   always_comb begin
      avail_cnt = '0;
      for (int i = 0; i < NUM_MOD; i++) avail_cnt = avail_cnt + CNT_W'(avail[i]);
   end

endmodule

// File: rtl/pas_swap_plan.sv
module pas_swap_plan
   import pas_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             judge,      // mismatch seen while comparison is live
   input  logic             bad_a,
   input  logic             bad_b,
   input  logic [CNT_W-1:0] spare_cnt,
   output plan_e            plan,
   output logic             suspect_both,
   output logic             stuck
);

   logic one_ok, two_ok;
   assign one_ok = spare_cnt >= CNT_W'(1);
   assign two_ok = spare_cnt >= CNT_W'(2);

   always_comb begin
      plan         = PLAN_HOLD;
      suspect_both = 1'b0;
      stuck        = 1'b0;
      if (judge) begin
         unique case ({bad_a, bad_b})
            2'b11: if (two_ok) plan = PLAN_REFILL_AB;
            2'b10: if (one_ok) plan = PLAN_REFILL_A;
            2'b01: if (one_ok) plan = PLAN_REFILL_B;
            default: begin
               if (two_ok) begin
                  plan         = PLAN_REFILL_AB;
                  suspect_both = 1'b1;
               end else begin
                  stuck = 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/pas_reconfig_ctrl.sv
module pas_reconfig_ctrl
   import pas_pkg::*;
#(
   parameter int NUM_MOD         = 4,
   parameter int DATA_W          = 16,
   parameter int LOW_INDEX_FIRST = 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [NUM_MOD*DATA_W-1:0]     mod_result,
   input  logic [NUM_MOD-1:0]            mod_err,
   output logic [DATA_W-1:0]             sys_out,
   output logic                          sys_valid,
   output logic                          busy,
   output logic                          exhausted,
   output logic                          unresolved,
   output logic [$clog2(NUM_MOD)-1:0]    act_a,
   output logic [$clog2(NUM_MOD)-1:0]    act_b
);

   localparam int IDX_W = $clog2(NUM_MOD);
   localparam int CNT_W = $clog2(NUM_MOD + 1);

   initial begin
      if (NUM_MOD < 3) $error("pas_reconfig_ctrl: NUM_MOD must be at least 3");
      if (DATA_W < 1)  $error("pas_reconfig_ctrl: DATA_W must be positive");
   end

   logic [IDX_W-1:0]   sel_a_q, sel_b_q;
   logic [NUM_MOD-1:0] mark_q;
   logic               busy_q, exh_q;

   logic [DATA_W-1:0]  word_a, word_b;
   logic [NUM_MOD-1:0] act_oh, cand, mark_nx;
   logic [IDX_W-1:0]   pick1, pick2;
   logic [CNT_W-1:0]   spare_cnt, live_cnt;
   logic               mism, judge, bad_a, bad_b, suspect_both, stuck;
   plan_e              plan;

   pas_word_sel #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel_a (
      .sel(sel_a_q), .bus(mod_result), .word(word_a));
   pas_word_sel #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel_b (
      .sel(sel_b_q), .bus(mod_result), .word(word_b));

   always_comb begin
      act_oh = '0;
      act_oh[sel_a_q] = 1'b1;
      act_oh[sel_b_q] = 1'b1;
   end

   assign cand  = ~(mark_q | mod_err) & ~act_oh;
   assign mism  = word_a != word_b;
   assign judge = mism && !busy_q && !exh_q;
   assign bad_a = mark_q[sel_a_q] | mod_err[sel_a_q];
   assign bad_b = mark_q[sel_b_q] | mod_err[sel_b_q];

   pas_spare_pick #(.NUM_MOD(NUM_MOD), .LOW_FIRST(LOW_INDEX_FIRST),
                    .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pick (
      .avail(cand), .first_idx(pick1), .second_idx(pick2), .avail_cnt(spare_cnt));

   pas_swap_plan #(.CNT_W(CNT_W)) u_plan (
      .judge(judge), .bad_a(bad_a), .bad_b(bad_b), .spare_cnt(spare_cnt),
      .plan(plan), .suspect_both(suspect_both), .stuck(stuck));

   assign mark_nx = mark_q | mod_err | (suspect_both ? act_oh : '0);

   always_comb begin
      live_cnt = '0;
      for (int i = 0; i < NUM_MOD; i++) live_cnt = live_cnt + CNT_W'(!mark_nx[i]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_a_q <= IDX_W'(0);
         sel_b_q <= IDX_W'(1);
         mark_q  <= '0;
         busy_q  <= 1'b0;
         exh_q   <= 1'b0;
      end else begin
         mark_q <= mark_nx;
         exh_q  <= exh_q | (live_cnt < CNT_W'(2));
         busy_q <= plan != PLAN_HOLD;
         unique case (plan)
            PLAN_REFILL_A:  sel_a_q <= pick1;
            PLAN_REFILL_B:  sel_b_q <= pick1;
            PLAN_REFILL_AB: begin
               sel_a_q <= pick1;
               sel_b_q <= pick2;
            end
            default: ;
         endcase
      end
   end

   assign sys_out    = word_a;
   assign sys_valid  = !mism && !busy_q && !exh_q;
   assign busy       = busy_q;
   assign exhausted  = exh_q;
   assign unresolved = stuck;
   assign act_a      = sel_a_q;
   assign act_b      = sel_b_q;

   // ---------------- assertions ----------------
   assert_pair_distinct_R11: assert property (@(posedge clk) disable iff (rst)
      sel_a_q != sel_b_q);

   assert_hold_on_match_R2: assert property (@(posedge clk) disable iff (rst)
      (!mism && !busy_q) |=> ($stable(sel_a_q) && $stable(sel_b_q)));

   assert_busy_single_R6: assert property (@(posedge clk) disable iff (rst)
      busy_q |=> !busy_q);

   assert_fresh_pair_healthy_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_q) |-> (!mark_q[sel_a_q] && !mark_q[sel_b_q]));

   assert_marks_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((mark_q & $past(mark_q)) == $past(mark_q)));

   assert_exhaust_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      exh_q |=> (exh_q && !sys_valid));

   assert_unresolved_holds_R8: assert property (@(posedge clk) disable iff (rst)
      stuck |=> ($stable(sel_a_q) && $stable(sel_b_q) && !busy_q));

endmodule

// File: tb/pas_reconfig_ctrl_tb.sv
module pas_reconfig_ctrl_tb;

   localparam int N = 4;
   localparam int W = 16;

   typedef struct {
      string       tag;
      logic        valid;
      logic [W-1:0] out;
      logic [1:0]  a;
      logic [1:0]  b;
      logic        bsy;
      logic        exh;
      logic        unr;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [N*W-1:0] mod_result = '0;
   logic [N-1:0]   mod_err = '0;
   logic [W-1:0]   sys_out;
   logic           sys_valid, busy, exhausted, unresolved;
   logic [1:0]     act_a, act_b;

   int   n_run = 0;
   int   n_fail = 0;
   bit   finished = 0;
   exp_t sb_q[$];
   exp_t cur;

   always #10 clk = ~clk;

   pas_reconfig_ctrl #(.NUM_MOD(N), .DATA_W(W)) u_dut (
      .clk(clk), .rst(rst), .mod_result(mod_result), .mod_err(mod_err),
      .sys_out(sys_out), .sys_valid(sys_valid), .busy(busy),
      .exhausted(exhausted), .unresolved(unresolved),
      .act_a(act_a), .act_b(act_b));

   // Driver: applies one cycle of stimulus and queues the expected outputs
   task automatic cyc(input logic [W-1:0] r0, r1, r2, r3, input logic [N-1:0] err,
                      input logic ev, input logic [W-1:0] eo, input logic [1:0] ea, eb,
                      input logic ebsy, eexh, eunr, input string tag);
      exp_t e;
      @(negedge clk);
      mod_result = {r3, r2, r1, r0};
      mod_err    = err;
      e.tag = tag; e.valid = ev; e.out = eo; e.a = ea; e.b = eb;
      e.bsy = ebsy; e.exh = eexh; e.unr = eunr;
      sb_q.push_back(e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      mod_result = '0;
      mod_err = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // Monitor: compares outputs against the queue head, off the active edge
   always begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
         cur = sb_q.pop_front();
         n_run++;
         if (sys_valid !== cur.valid || act_a !== cur.a || act_b !== cur.b ||
             busy !== cur.bsy || exhausted !== cur.exh || unresolved !== cur.unr ||
             (cur.valid && sys_out !== cur.out)) begin
            n_fail++;
            $display("FAIL %s: got v=%0b out=%h a=%0d b=%0d busy=%0b exh=%0b unr=%0b, expected v=%0b out=%h a=%0d b=%0d busy=%0b exh=%0b unr=%0b",
                     cur.tag, sys_valid, sys_out, act_a, act_b, busy, exhausted, unresolved,
                     cur.valid, cur.out, cur.a, cur.b, cur.bsy, cur.exh, cur.unr);
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state, R2 forwarding
      cyc(16'h1111, 16'h1111, 16'h1111, 16'h1111, 4'b0000, 1, 16'h1111, 0, 1, 0, 0, 0, "R1 reset pair");
      cyc(16'hAAAA, 16'hAAAA, 16'h0005, 16'h0006, 4'b0000, 1, 16'hAAAA, 0, 1, 0, 0, 0, "R2 spares ignored");
      cyc(16'h1234, 16'h1234, 16'hFFFF, 16'h0000, 4'b0000, 1, 16'h1234, 0, 1, 0, 0, 0, "R2 pair held");
      // R3: module 1 flags during mismatch, slot B refilled with module 2
      cyc(16'h0001, 16'h0002, 16'h0003, 16'h0003, 4'b0010, 0, 16'h0, 0, 1, 0, 0, 0, "R3 mismatch cycle");
      cyc(16'h3333, 16'h3333, 16'h3333, 16'h3333, 4'b0000, 0, 16'h0, 0, 2, 1, 0, 0, "R6 busy after swap B");
      cyc(16'h4444, 16'h3333, 16'h4444, 16'h3333, 4'b0000, 1, 16'h4444, 0, 2, 0, 0, 0, "R6 busy one cycle");
      // R4/R5: module 0 fails, module 1 (lower index) stays excluded, 3 is picked
      cyc(16'h0007, 16'h0000, 16'h0008, 16'h0000, 4'b0001, 0, 16'h0, 0, 2, 0, 0, 0, "R3 mismatch slot A");
      cyc(16'h5555, 16'h5555, 16'h5555, 16'h5555, 4'b0000, 0, 16'h0, 3, 2, 1, 0, 0, "R5 retired not reused");
      cyc(16'h0000, 16'h0000, 16'h6666, 16'h6666, 4'b0000, 1, 16'h6666, 3, 2, 0, 0, 0, "R2 out from slot A");
      // R8: no faulty member, no spares left
      cyc(16'h0000, 16'h0000, 16'h000A, 16'h0009, 4'b0000, 0, 16'h0, 3, 2, 0, 0, 1, "R8 unresolved");
      cyc(16'h0000, 16'h0000, 16'h7777, 16'h7777, 4'b0000, 1, 16'h7777, 3, 2, 0, 0, 0, "R8 selection kept");
      // R9: module 2 fails with no spare
      cyc(16'h0000, 16'h0000, 16'h0002, 16'h0001, 4'b0100, 0, 16'h0, 3, 2, 0, 0, 0, "R9 last fault");
      cyc(16'h0000, 16'h0000, 16'h8888, 16'h8888, 4'b0000, 0, 16'h0, 3, 2, 0, 1, 0, "R9 exhausted");
      cyc(16'h0000, 16'h0000, 16'h9999, 16'h9999, 4'b0000, 0, 16'h0, 3, 2, 0, 1, 0, "R9 exhausted sticky");

      // R7: both suspect, two spares
      do_reset();
      cyc(16'h1111, 16'h1111, 16'h0, 16'h0, 4'b0000, 1, 16'h1111, 0, 1, 0, 0, 0, "R1 after second reset");
      cyc(16'h0001, 16'h0002, 16'h0, 16'h0, 4'b0000, 0, 16'h0, 0, 1, 0, 0, 0, "R7 mismatch no flag");
      cyc(16'h0, 16'h0, 16'hBBBB, 16'hBBBB, 4'b0000, 0, 16'h0, 2, 3, 1, 0, 0, "R7 both refilled");
      cyc(16'h0, 16'h0, 16'hBBBB, 16'hBBBB, 4'b0000, 1, 16'hBBBB, 2, 3, 0, 0, 0, "R7 new pair live");
      cyc(16'h0, 16'h0, 16'h0001, 16'h0002, 4'b1000, 0, 16'h0, 2, 3, 0, 0, 0, "R9 suspects marked");
      cyc(16'h0, 16'h0, 16'h0001, 16'h0001, 4'b0000, 0, 16'h0, 2, 3, 0, 1, 0, "R9 pool empty");

      // R10: both active flagged
      do_reset();
      cyc(16'h0001, 16'h0002, 16'h0, 16'h0, 4'b0011, 0, 16'h0, 0, 1, 0, 0, 0, "R10 both flagged");
      cyc(16'h0, 16'h0, 16'hCCCC, 16'hCCCC, 4'b0000, 0, 16'h0, 2, 3, 1, 0, 0, "R10 priority order R4");
      cyc(16'h0, 16'h0, 16'hCCCC, 16'hCCCC, 4'b0000, 1, 16'hCCCC, 2, 3, 0, 0, 0, "R10 resumed");

      // R5 same cycle: spare 2 flags while slot B is being refilled
      do_reset();
      cyc(16'h0001, 16'h0002, 16'h0, 16'h0, 4'b0110, 0, 16'h0, 0, 1, 0, 0, 0, "R5 flag on spare");
      cyc(16'hDDDD, 16'h0, 16'h0, 16'hDDDD, 4'b0000, 0, 16'h0, 0, 3, 1, 0, 0, "R5 flagged spare skipped");
      cyc(16'hDDDD, 16'h0, 16'h0, 16'hDDDD, 4'b0000, 1, 16'hDDDD, 0, 3, 0, 0, 0, "R11 pair shown");

      @(negedge clk);
      #5;
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule